// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a segment:offset pair into a 20-bit physical memory address, the way the bus side of a 16-bit segmented processor does. It keeps four 16-bit segment registers: code, data, extra and stack. Each request is either an instruction fetch or an operand access. A fetch always pairs the code segment with the supplied instruction pointer. An operand access pairs the segment register named by the request with a supplied effective address.

The segment value is shifted left by four bit positions, which multiplies it by 16. The offset is then added, and anything above bit 19 is dropped. The result is presented one clock later on a registered address output, together with a valid strobe. Segment registers are loaded through a write port. Working out the effective address and running the memory cycle are left to neighbouring logic.

Top module: `seg_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released, the code segment holds FFFFH and the data, extra and stack segments hold 0000H. After reset, `addr_valid` is 0 and `addr_out` is 00000H.
- R2: The output address equals the segment value times 16 plus the zero-extended 16-bit offset, taken modulo 2^20.
- R3: When `req_fetch` is 1, the code segment and `ip_in` are used. `req_seg` and `ea_in` have no effect on the result.
- R4: When `req_fetch` is 0, `req_seg` picks the segment and `ea_in` is the offset. The encoding is 00 = extra, 01 = code, 10 = stack, 11 = data. `ip_in` has no effect on the result.
- R5: `addr_valid` is 1 exactly in the cycle after a clock edge at which `req_valid` was 1, and 0 otherwise.
- R6: `addr_out` keeps its value across cycles in which no request is accepted.
- R7: A segment write with `seg_wr_en` = 1 updates the register selected by `seg_wr_sel` (same encoding as R4) at the clock edge. A request accepted at that same edge still uses the old value. Later requests use the new value.
- R8: A sum that carries out of bit 19 wraps around. For example, segment FFFFH with offset 0010H gives 00000H.
- R9: Code segment 20A8H with instruction pointer 2008H gives the fetch address 22A88H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| seg_wr_en | input | 1 | Segment register write enable |
| seg_wr_sel | input | 2 | Segment register to write (R4 encoding) |
| seg_wr_data | input | 16 | Value to write |
| req_valid | input | 1 | Request present this cycle |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = operand access |
| req_seg | input | 2 | Segment select for an operand access |
| ip_in | input | 16 | Instruction pointer offset |
| ea_in | input | 16 | Effective address offset |
| addr_out | output | 20 | Registered physical address |
| addr_valid | output | 1 | Registered strobe marking a new address |

## Verification
A wrong segment register value is not visible by itself. It shows up on `addr_out` one cycle after the first request that selects that register. For this reason the bench reads every register back through a request with offset zero, and compares each address against its own model of the four segments. A wrong decode of the select encoding appears as an address built from the wrong base, again one cycle later. A failure to drop the carry is only visible on requests whose sum exceeds FFFFFH, so such sums are driven on purpose. A read-during-write ordering error appears only when a write and a request share a clock edge, so that case is driven directly.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int SEG_W   = 16;
  localparam int OFF_W   = 16;
  localparam int SHIFT   = 4;
  localparam int ADDR_W  = 20;
  localparam int NSEG    = 4;
  localparam int SEL_W   = $clog2(NSEG);

  typedef enum logic [1:0] {
    SEG_EXTRA = 2'b00,
    SEG_CODE  = 2'b01,
    SEG_STACK = 2'b10,
    SEG_DATA  = 2'b11
  } seg_sel_e;

  typedef struct packed {
    logic                 fetch;
    logic [SEL_W-1:0]     sel;
    logic [OFF_W-1:0]     ip;
    logic [OFF_W-1:0]     ea;
  } seg_req_t;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_addr_pkg::*;
#(
  parameter int W        = SEG_W,
  parameter int N        = NSEG,
  parameter int CODE_IDX = 1,
  localparam int SW      = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [SW-1:0]  wr_sel,
  input  logic [W-1:0]   wr_data,
  output logic [N*W-1:0] seg_flat
);
  for (genvar g = 0; g < N; g++) begin : g_seg
    localparam logic [W-1:0] RST_VAL = (g == CODE_IDX) ? {W{1'b1}} : {W{1'b0}};
    logic         en;
    logic [W-1:0] q;
    logic [W-1:0] d;

    always_comb begin
      en = wr_en && (wr_sel == SW'(g));
      d  = en ? wr_data : q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= d;
    end

    assign seg_flat[g*W +: W] = q;
  end
endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_addr_pkg::*;
#(
  parameter int W  = SEG_W,
  parameter int OW = OFF_W,
  parameter int N  = NSEG,
  localparam int SW = $clog2(N)
) (
  input  logic [N*W-1:0] seg_flat,
  input  logic           fetch,
  input  logic [SW-1:0]  sel,
  input  logic [OW-1:0]  ip,
  input  logic [OW-1:0]  ea,
  output logic [W-1:0]   seg_val,
  output logic [OW-1:0]  off_val
);
  logic [SW-1:0] idx;

  always_comb begin
    idx     = fetch ? SW'(SEG_CODE) : sel;
    seg_val = seg_flat[idx*W +: W];
    off_val = fetch ? ip : ea;
  end
endmodule

// File: rtl/seg_addr_adder.sv
module seg_addr_adder
  import seg_addr_pkg::*;
#(
  parameter int W  = SEG_W,
  parameter int OW = OFF_W,
  parameter int SH = SHIFT,
  parameter int AW = ADDR_W
) (
  input  logic [W-1:0]  seg_val,
  input  logic [OW-1:0] off_val,
  output logic [AW-1:0] phys
);
  localparam int BW = W + SH;
  logic [BW-1:0] base_wide;
  logic [AW-1:0] base;
  logic [AW-1:0] off_ext;

  always_comb begin
    base_wide = {seg_val, {SH{1'b0}}};
    base      = AW'(base_wide);
    off_ext   = AW'(off_val);
    phys      = base + off_ext;
  end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seg_wr_en,
  input  logic [SEL_W-1:0]  seg_wr_sel,
  input  logic [SEG_W-1:0]  seg_wr_data,
  input  logic              req_valid,
  input  logic              req_fetch,
  input  logic [SEL_W-1:0]  req_seg,
  input  logic [OFF_W-1:0]  ip_in,
  input  logic [OFF_W-1:0]  ea_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              addr_valid
);
  logic [1:0]            rst_pipe;
  logic                  rst_sync_n;
  logic [NSEG*SEG_W-1:0] seg_flat;
  logic [SEG_W-1:0]      seg_val;
  logic [OFF_W-1:0]      off_val;
  logic [ADDR_W-1:0]     phys;
  logic [ADDR_W-1:0]     addr_d;
  logic                  valid_d;
  seg_req_t              req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign req = '{fetch: req_fetch, sel: req_seg, ip: ip_in, ea: ea_in};

  seg_regfile #(.W(SEG_W), .N(NSEG), .CODE_IDX(int'(SEG_CODE))) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (seg_wr_en),
    .wr_sel  (seg_wr_sel),
    .wr_data (seg_wr_data),
    .seg_flat(seg_flat)
  );

  seg_select #(.W(SEG_W), .OW(OFF_W), .N(NSEG)) u_sel (
    .seg_flat(seg_flat),
    .fetch   (req.fetch),
    .sel     (req.sel),
    .ip      (req.ip),
    .ea      (req.ea),
    .seg_val (seg_val),
    .off_val (off_val)
  );

  seg_addr_adder #(.W(SEG_W), .OW(OFF_W), .SH(SHIFT), .AW(ADDR_W)) u_add (
    .seg_val(seg_val),
    .off_val(off_val),
    .phys   (phys)
  );

  always_comb begin
    valid_d = req_valid;
    addr_d  = req_valid ? phys : addr_out;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_out   <= '0;
      addr_valid <= 1'b0;
    end else begin
      addr_out   <= addr_d;
      addr_valid <= valid_d;
    end
  end
endmodule

// File: rtl/seg_addr_gen_checker.sv
module seg_addr_gen_checker
  import seg_addr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_fetch,
  input logic [SEL_W-1:0]  req_seg,
  input logic [OFF_W-1:0]  ip_in,
  input logic [OFF_W-1:0]  ea_in,
  input logic              seg_wr_en,
  input logic [SEL_W-1:0]  seg_wr_sel,
  input logic [SEG_W-1:0]  seg_wr_data,
  input logic [NSEG*SEG_W-1:0] seg_flat,
  input logic [ADDR_W-1:0] addr_out,
  input logic              addr_valid
);
  logic [SEG_W-1:0] code_seg;
  logic [ADDR_W-1:0] fetch_exp;
  assign code_seg  = seg_flat[int'(SEG_CODE)*SEG_W +: SEG_W];
  assign fetch_exp = ADDR_W'({code_seg, {SHIFT{1'b0}}}) + ADDR_W'(ip_in);

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> addr_valid); // R5
  AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !addr_valid); // R5
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(addr_out)); // R6
  AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_fetch) |=> addr_out == $past(fetch_exp)); // R3
  AST_SEG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    seg_wr_en |=> seg_flat[$past(seg_wr_sel)*SEG_W +: SEG_W] == $past(seg_wr_data)); // R7
endmodule

bind seg_addr_gen seg_addr_gen_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .req_valid  (req_valid),
  .req_fetch  (req_fetch),
  .req_seg    (req_seg),
  .ip_in      (ip_in),
  .ea_in      (ea_in),
  .seg_wr_en  (seg_wr_en),
  .seg_wr_sel (seg_wr_sel),
  .seg_wr_data(seg_wr_data),
  .seg_flat   (seg_flat),
  .addr_out   (addr_out),
  .addr_valid (addr_valid)
);

// File: tb/seg_addr_gen_bench.sv
module seg_addr_gen_bench;
  logic        clk;
  logic        rst_n;
  logic        seg_wr_en;
  logic [1:0]  seg_wr_sel;
  logic [15:0] seg_wr_data;
  logic        req_valid;
  logic        req_fetch;
  logic [1:0]  req_seg;
  logic [15:0] ip_in;
  logic [15:0] ea_in;
  logic [19:0] addr_out;
  logic        addr_valid;

  int compared = 0;
  int mismatched = 0;
  logic [15:0] model [4];

  seg_addr_gen u_seg_addr_gen (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    logic [20:0] wide;
    wide = {1'b0, s, 4'h0} + {5'h0, o};
    return wide[19:0];
  endfunction

  task automatic check(input string req, input logic [19:0] got, input logic [19:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %05h expected %05h", req, got, exp);
    end
  endtask

  task automatic write_seg(input logic [1:0] sel, input logic [15:0] v);
    @(negedge clk);
    seg_wr_en = 1'b1; seg_wr_sel = sel; seg_wr_data = v;
    @(negedge clk);
    seg_wr_en = 1'b0;
    model[sel] = v;
  endtask

  task automatic request(input logic f, input logic [1:0] s,
                         input logic [15:0] ip, input logic [15:0] ea);
    @(negedge clk);
    req_valid = 1'b1; req_fetch = f; req_seg = s; ip_in = ip; ea_in = ea;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 valid after reset", {19'h0, addr_valid}, 20'h0);
    check("R1 addr after reset", addr_out, 20'h0);
    request(1'b1, 2'b00, 16'h0000, 16'h1234);
    check("R1 code resets to FFFF", addr_out, 20'hFFFF0);
    for (int i = 0; i < 4; i++) begin
      if (i != 1) begin
        request(1'b0, 2'(i), 16'h5555, 16'h0000);
        check("R1 other segments reset to 0", addr_out, 20'h0);
      end
    end
  endtask

  task automatic t_example;
    write_seg(2'b01, 16'h20A8);
    request(1'b1, 2'b11, 16'h2008, 16'h0000);
    check("R9 example fetch", addr_out, 20'h22A88);
  endtask

  task automatic t_fetch;
    write_seg(2'b00, 16'h1000);
    write_seg(2'b11, 16'h3000);
    request(1'b1, 2'b00, 16'h0044, 16'hBEEF);
    check("R3 fetch ignores seg and ea", addr_out, phys(model[1], 16'h0044));
    request(1'b1, 2'b11, 16'h0044, 16'h0001);
    check("R3 fetch ignores seg select", addr_out, phys(model[1], 16'h0044));
  endtask

  task automatic t_operand;
    write_seg(2'b00, 16'h1111);
    write_seg(2'b01, 16'h2222);
    write_seg(2'b10, 16'h3333);
    write_seg(2'b11, 16'h4444);
    for (int i = 0; i < 4; i++) begin
      request(1'b0, 2'(i), 16'hFFFF, 16'h0123);
      check("R4 operand select encoding", addr_out, phys(model[i], 16'h0123));
    end
  endtask

  task automatic t_wrap;
    write_seg(2'b10, 16'hFFFF);
    request(1'b0, 2'b10, 16'h0000, 16'h0010);
    check("R8 wrap to zero", addr_out, 20'h00000);
    request(1'b0, 2'b10, 16'h0000, 16'hFFFF);
    check("R8 wrap high offset", addr_out, 20'h0FFEF);
  endtask

  task automatic t_hold;
    logic [19:0] last;
    request(1'b0, 2'b11, 16'h0000, 16'h0777);
    check("R5 valid one cycle after request", {19'h0, addr_valid}, 20'h1);
    last = addr_out;
    ea_in = 16'h9999; ip_in = 16'h8888; req_fetch = 1'b1;
    @(negedge clk);
    check("R5 valid low when idle", {19'h0, addr_valid}, 20'h0);
    check("R6 addr held when idle", addr_out, last);
    @(negedge clk);
    check("R6 addr still held", addr_out, last);
  endtask

  task automatic t_collision;
    logic [15:0] old;
    old = model[3];
    @(negedge clk);
    seg_wr_en = 1'b1; seg_wr_sel = 2'b11; seg_wr_data = 16'hA5A5;
    req_valid = 1'b1; req_fetch = 1'b0; req_seg = 2'b11; ea_in = 16'h0002;
    @(negedge clk);
    seg_wr_en = 1'b0; req_valid = 1'b0;
    model[3] = 16'hA5A5;
    check("R7 same-edge request uses old value", addr_out, phys(old, 16'h0002));
    request(1'b0, 2'b11, 16'h0000, 16'h0002);
    check("R7 later request uses new value", addr_out, phys(16'hA5A5, 16'h0002));
  endtask

  task automatic t_random;
    logic [15:0] s;
    logic [15:0] o;
    logic [1:0]  k;
    for (int n = 0; n < 40; n++) begin
      s = 16'($urandom); o = 16'($urandom); k = 2'($urandom);
      write_seg(k, s);
      request(1'b0, k, 16'($urandom), o);
      check("R2 general address sum", addr_out, phys(s, o));
    end
  endtask

  initial begin
    #(8 * 200000);
    mismatched++;
    compared++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst_n = 1'b0; seg_wr_en = 1'b0; seg_wr_sel = '0; seg_wr_data = '0;
    req_valid = 1'b0; req_fetch = 1'b0; req_seg = '0; ip_in = '0; ea_in = '0;
    model[0] = 16'h0000; model[1] = 16'hFFFF; model[2] = 16'h0000; model[3] = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_example();
    t_fetch();
    t_operand();
    t_wrap();
    t_hold();
    t_collision();
    t_random();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule